// File: doc/BRIEF.md
# Memory Controller Performance Counter Bank

This block is a bank of four event counters that watches a memory controller. Software reaches it through a small word-addressed register port: one write strobe, one read strobe and a shared byte address. Every counter has a control word and a read-only count word. Slot 0 counts clock cycles only. Slots 1 to 3 each count the event picked by an 8-bit select code. The code indexes a 256-wide vector of per-cycle event strobes supplied by the controller.

Each slot has a run bit and a sticky wrap flag. Writing the control word with both the run bit and the zeroing bit set restarts the slot from zero. The wrap flag of the cycle slot drives the interrupt line. Event codes 0x41 and 0x42 count only transactions whose ID matches a programmable filter register.

Top module: `mc_perf_bank`

## Requirements
- R1: After a synchronous active-high reset, every control, count and filter register reads zero and `irq` is low.
- R2: Register map. Slot n has its control word at byte offset 0x00+4n and its count word at 0x20+4n. The filter register is at 0x30. Control word layout: bit 0 is the wrap flag, bit 1 zeroes the count (it always reads 0), bit 2 is the run bit, and bits 31:24 hold the select code. The other bits read 0. Read data appears on `rd_data` with `rd_valid` high one cycle after `rd_en`.
- R3: A control write with bits 2 and 1 set zeroes the count and starts counting from the next cycle. A write with bit 2 clear stops the slot, and the count then holds.
- R4: While running, slots 1 to 3 add one in each cycle in which the strobe chosen by their select code is high. Code 0x00 selects every cycle.
- R5: Slot 0 counts every cycle while running, whatever select code is written. Its select field always reads 0x00.
- R6: Counts wrap modulo 2^CNT_W (32 by default). A wrap sets the slot's wrap flag, and the slot keeps counting.
- R7: The wrap flag is sticky. A control write with bit 1 set, or with bit 0 written as 0, clears it. A write with bit 0 as 1 and bit 1 as 0 leaves it unchanged.
- R8: `irq` rises when slot 0 wraps. It stays high until slot 0's wrap flag is cleared. Wraps of the other slots never drive it.
- R9: Codes 0x41 and 0x42 count a strobe only in cycles where `txn_valid` is high and `txn_id` equals the filter register.
- R10: Reads of unmapped or unaligned offsets return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset for the read or write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| ev_strobe | input | 256 | Per-cycle event strobes, indexed by event code |
| txn_id | input | ID_W | Transaction ID for the filtered events |
| txn_valid | input | 1 | Qualifies `txn_id` |
| irq | output | 1 | Cycle-slot wrap interrupt, level until cleared |

## Verification
A write takes effect at the clock edge that samples it. A running slot first counts at the following edge. A read answers one edge after its strobe. The scoreboard queues an expected word when a read is issued and compares it in the falling-edge half of the cycle in which `rd_valid` is high. Every count check stops the slot first, so the expected value is the exact number of edges at which the slot ran with its strobe high. The interrupt is sampled at the falling edge after the wrap edge, and again after the clearing write.

// File: rtl/mc_perf_pkg.sv
package mc_perf_pkg;
    localparam int NUM_SLOT  = 4;
    localparam int SLOT_IW   = $clog2(NUM_SLOT);
    localparam int CODE_W    = 8;
    localparam int NUM_EV    = 1 << CODE_W;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;

    localparam logic [CODE_W-1:0] CODE_CYCLE  = 8'h00;
    localparam logic [CODE_W-1:0] CODE_ID_RD  = 8'h41;
    localparam logic [CODE_W-1:0] CODE_ID_WR  = 8'h42;

    localparam logic [ADDR_W-1:0] BASE_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] BASE_COUNT = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_FILTER = 8'h30;

    typedef enum logic [1:0] {
        HIT_NONE,
        HIT_CTRL,
        HIT_COUNT,
        HIT_FILTER
    } hit_kind_e;

    typedef struct packed {
        hit_kind_e           kind;
        logic [SLOT_IW-1:0]  slot;
    } reg_hit_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              run;
        logic              wrap;
    } slot_cfg_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              run;
        logic              zero;
        logic              keep_wrap;
    } ctrl_wr_t;

    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_hit_t h;
        h.kind = HIT_NONE;
        h.slot = a[SLOT_IW+1:2];
        if (a[1:0] == 2'b00) begin
            if (a >= BASE_CTRL && a < BASE_CTRL + ADDR_W'(4 * NUM_SLOT))
                h.kind = HIT_CTRL;
            else if (a >= BASE_COUNT && a < BASE_COUNT + ADDR_W'(4 * NUM_SLOT))
                h.kind = HIT_COUNT;
            else if (a == OFS_FILTER)
                h.kind = HIT_FILTER;
        end
        return h;
    endfunction

    function automatic ctrl_wr_t unpack_ctrl(input logic [DATA_W-1:0] d);
        ctrl_wr_t c;
        c.code      = d[31:24];
        c.run       = d[2];
        c.zero      = d[1];
        c.keep_wrap = d[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input slot_cfg_t c);
        return {c.code, 21'd0, c.run, 1'b0, c.wrap};
    endfunction
endpackage

// File: rtl/mc_perf_filter.sv
module mc_perf_filter
    import mc_perf_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic [NUM_EV-1:0] ev_in,
    input  logic [ID_W-1:0]   txn_id,
    input  logic              txn_valid,
    input  logic [ID_W-1:0]   match_id,
    output logic [NUM_EV-1:0] ev_out
);
    logic id_hit;
    assign id_hit = txn_valid && (txn_id == match_id);

    always_comb begin
        ev_out             = ev_in;
        ev_out[CODE_CYCLE] = 1'b1;
        ev_out[CODE_ID_RD] = ev_in[CODE_ID_RD] & id_hit;
        ev_out[CODE_ID_WR] = ev_in[CODE_ID_WR] & id_hit;
    end
endmodule

// File: rtl/mc_perf_slot.sv
module mc_perf_slot
    import mc_perf_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter bit CYCLE_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  ctrl_wr_t          wr_fields,
    input  logic [NUM_EV-1:0] ev_eff,
    output slot_cfg_t         cfg_q,
    output logic [CNT_W-1:0]  count_q
);
    logic tick;

    generate
        if (CYCLE_ONLY) begin : g_cycle
            assign tick = 1'b1;
        end else begin : g_event
            assign tick = ev_eff[cfg_q.code];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            count_q <= '0;
        end else if (wr_ctrl) begin
            cfg_q.run  <= wr_fields.run;
            cfg_q.code <= CYCLE_ONLY ? CODE_CYCLE : wr_fields.code;
            if (wr_fields.zero || !wr_fields.keep_wrap)
                cfg_q.wrap <= 1'b0;
            if (wr_fields.zero)
                count_q <= '0;
        end else if (cfg_q.run && tick) begin
            count_q <= count_q + 1'b1;
            if (&count_q)
                cfg_q.wrap <= 1'b1;
        end
    end

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.run && !wr_ctrl) |=>
        ((count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.run && !wr_ctrl) |=> $stable(count_q));

    // R3
    zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wr_fields.zero) |=> (count_q == '0 && !cfg_q.wrap));

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_q.wrap) |-> (count_q == '0));
endmodule

// File: rtl/mc_perf_bank.sv
module mc_perf_bank
    import mc_perf_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int ID_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic [NUM_EV-1:0] ev_strobe,
    input  logic [ID_W-1:0]   txn_id,
    input  logic              txn_valid,
    output logic              irq
);
    reg_hit_t          hit;
    ctrl_wr_t          fields;
    logic [ID_W-1:0]   filter_q;
    logic [NUM_EV-1:0] ev_eff;
    slot_cfg_t         cfg [NUM_SLOT];
    logic [CNT_W-1:0]  cnt [NUM_SLOT];
    logic [DATA_W-1:0] cnt_ext [NUM_SLOT];

    assign hit    = decode_addr(addr);
    assign fields = unpack_ctrl(wr_data);

    mc_perf_filter #(.ID_W(ID_W)) u_filter (
        .ev_in     (ev_strobe),
        .txn_id    (txn_id),
        .txn_valid (txn_valid),
        .match_id  (filter_q),
        .ev_out    (ev_eff)
    );

    generate
        for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
            mc_perf_slot #(
                .CNT_W      (CNT_W),
                .CYCLE_ONLY (s == 0)
            ) u_slot (
                .clk       (clk),
                .rst       (rst),
                .wr_ctrl   (wr_en && hit.kind == HIT_CTRL && hit.slot == SLOT_IW'(s)),
                .wr_fields (fields),
                .ev_eff    (ev_eff),
                .cfg_q     (cfg[s]),
                .count_q   (cnt[s])
            );
            always_comb begin
                cnt_ext[s]            = '0;
                cnt_ext[s][CNT_W-1:0] = cnt[s];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            filter_q <= '0;
        else if (wr_en && hit.kind == HIT_FILTER)
            filter_q <= wr_data[ID_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                case (hit.kind)
                    HIT_CTRL:   rd_data <= pack_ctrl(cfg[hit.slot]);
                    HIT_COUNT:  rd_data <= cnt_ext[hit.slot];
                    HIT_FILTER: rd_data <= DATA_W'(filter_q);
                    default:    rd_data <= '0;
                endcase
            end
        end
    end

    assign irq = cfg[0].wrap;

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && hit.kind == HIT_NONE) |=> (rd_data == '0));

    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit.kind == HIT_NONE) |=> $stable(filter_q));

    // R8
    irq_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (cnt[0] == '0));
endmodule

// File: tb/mc_perf_bank_bench.sv
module mc_perf_bank_bench;
    localparam int CW = 12;
    localparam int IW = 16;
    localparam int WRAP = 1 << CW;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [7:0]  addr;
    logic [31:0] wr_data, rd_data;
    logic        rd_valid;
    logic [255:0] ev_strobe;
    logic [IW-1:0] txn_id;
    logic        txn_valid;
    logic        irq;

    int tests = 0;
    int fails = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    mc_perf_bank #(.CNT_W(CW), .ID_W(IW)) u_mc_perf_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .ev_strobe(ev_strobe), .txn_id(txn_id), .txn_valid(txn_valid), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("unexpected read response", rd_data, 32'hx);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wr_data = '0;
    endtask

    task automatic reg_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        idle(2);
        if (exp_q.size() != 0) check("pending reads", 32'(exp_q.size()), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0;
        ev_strobe = '0; txn_id = '0; txn_valid = 0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        check("R1 irq after reset", 32'(irq), 0);
        reg_rd(8'h00, 32'h0, "R1 ctrl0 reset");
        reg_rd(8'h24, 32'h0, "R1 count1 reset");
        reg_rd(8'h30, 32'h0, "R1 filter reset");

        // R5 cycle slot ignores select code; R3 run 20 cycles then stop
        reg_wr(8'h00, 32'h5500_0006);
        idle(20);
        reg_wr(8'h00, 32'h0);
        reg_rd(8'h20, 32'd20, "R5 cycle slot count");
        reg_rd(8'h00, 32'h0, "R5 cycle slot select reads zero");

        // R4 event counting on slots 1 and 2
        reg_wr(8'h04, 32'h0400_0006);
        reg_wr(8'h08, 32'h0500_0006);
        for (int i = 0; i < 12; i++) begin
            ev_strobe[8'h04] = (i < 7);
            ev_strobe[8'h05] = (i % 3 == 0);
            @(negedge clk);
        end
        ev_strobe = '0;
        reg_wr(8'h04, 32'h0400_0000);
        reg_wr(8'h08, 32'h0500_0000);
        reg_rd(8'h24, 32'd7, "R4 slot1 code 0x04");
        reg_rd(8'h28, 32'd4, "R4 slot2 code 0x05");
        reg_rd(8'h04, 32'h0400_0000, "R2 ctrl1 fields");

        // R3 stopped slot holds
        for (int i = 0; i < 3; i++) begin
            ev_strobe[8'h04] = 1'b1;
            @(negedge clk);
        end
        ev_strobe = '0;
        reg_rd(8'h24, 32'd7, "R3 stopped slot holds");

        // R9 ID filter
        reg_wr(8'h30, 32'h0000_003A);
        reg_wr(8'h0C, 32'h4100_0006);
        for (int i = 0; i < 10; i++) begin
            ev_strobe[8'h41] = 1'b1;
            ev_strobe[8'h42] = 1'b1;
            txn_valid = (i < 7) || (i == 9 && 1'b0);
            txn_id = (i < 4 || i >= 7) ? 16'h003A : 16'h003B;
            @(negedge clk);
        end
        ev_strobe = '0; txn_valid = 0; txn_id = '0;
        reg_wr(8'h0C, 32'h4100_0000);
        reg_rd(8'h2C, 32'd4, "R9 filtered read events");
        reg_rd(8'h30, 32'h3A, "R2 filter readback");

        // R4 code 0x00 on slot 1, R6 wrap sets sticky flag, no irq
        reg_wr(8'h04, 32'h0000_0006);
        idle(WRAP + 5);
        reg_wr(8'h04, 32'h0000_0001);
        reg_rd(8'h24, 32'd5, "R6 slot1 keeps counting after wrap");
        reg_rd(8'h04, 32'h0000_0001, "R7 wrap flag kept by bit0=1");
        check("R8 slot1 wrap does not raise irq", 32'(irq), 0);
        reg_wr(8'h04, 32'h0);
        reg_rd(8'h04, 32'h0, "R7 wrap flag cleared by bit0=0");

        // R8 cycle slot wrap raises irq
        reg_wr(8'h00, 32'h0000_0006);
        idle(WRAP - 1);
        check("R8 irq low before wrap", 32'(irq), 0);
        idle(1);
        check("R8 irq high after wrap", 32'(irq), 1);
        idle(3);
        reg_wr(8'h00, 32'h0000_0005);
        check("R7 irq held when bit0=1", 32'(irq), 1);
        reg_wr(8'h00, 32'h0000_0006);
        check("R8 irq cleared by zeroing write", 32'(irq), 0);
        reg_wr(8'h00, 32'h0);

        // R10 unmapped and unaligned accesses
        reg_wr(8'h10, 32'hFFFF_FFFF);
        reg_wr(8'h34, 32'hFFFF_FFFF);
        reg_wr(8'h31, 32'hFFFF_FFFF);
        reg_rd(8'h10, 32'h0, "R10 unmapped read 0x10");
        reg_rd(8'h34, 32'h0, "R10 unmapped read 0x34");
        reg_rd(8'h30, 32'h3A, "R10 filter untouched");
        reg_rd(8'h2C, 32'd4, "R10 slot3 count untouched");

        finish_run();
    end
endmodule